// File: doc/BRIEF.md
# SPI Host Controller with Byte FIFOs

This block is a memory-mapped SPI master. Software places bytes in a transmit FIFO through a 32-bit register port. While software has not blocked transfers, the controller takes bytes from that FIFO one at a time. It shifts each byte out on MOSI and, during the same eight clock periods, captures one byte from MISO into a receive FIFO. Software then reads the received bytes back through the same register port.

Several registers sit beside the data path:
- a control word holding the transfer-inhibit flag and two one-shot FIFO clear bits;
- a read-only status word;
- a select register that drives the active-low chip selects;
- two occupancy registers;
- a keyed soft reset.

Level and pulse event outputs feed an external interrupt unit. Accesses are whole, aligned 32-bit words, and `reg_rdata` is a combinational view of the addressed register. A read takes effect, for example popping the receive FIFO, at the clock edge on which `reg_rd` is high. The parameter CLK_DIV must be even and at least 2.

Top module: `spi_host_ctrl`

## Requirements
- R1: Writing exactly 0x0000000A to offset 0x40 returns every register, both FIFOs and the shifter to the reset state on the next edge. Any other value written there has no effect.
- R2: In the control word at offset 0x60, bit 5 empties the transmit FIFO and bit 6 empties the receive FIFO. Each acts once, and neither is kept: both read back as 0.
- R3: While control bit 8 (inhibit) is 1, no new byte starts and SCLK stays low. When a control write clears bit 8, draining of the waiting transmit bytes begins.
- R4: The status word at offset 0x64 has bit 0 = receive empty, bit 1 = receive full, bit 2 = transmit empty and bit 3 = transmit full. Writes to it change nothing. The outputs ev_rx_nonempty, ev_rx_full and ev_tx_empty follow the same FIFO conditions.
- R5: A write to offset 0x68 queues the low 8 bits of the data word for transmission. A write made while the transmit FIFO already holds FIFO_DEPTH bytes is dropped.
- R6: A read of offset 0x6C returns the oldest received byte in bits 7:0 with zeros above, and removes it from the receive FIFO. On an empty receive FIFO the read returns 0xDEADBEEF and removes nothing.
- R7: A byte that completes while the receive FIFO is full is discarded. ev_rx_overrun then pulses high for one cycle.
- R8: The select register at offset 0x70 resets to all ones, and ss_n[i] is low exactly when bit i of that register is 0.
- R9: The transmit occupancy (offset 0x74) and receive occupancy (offset 0x78) each read the stored byte count minus one, or 0 when the FIFO is empty.
- R10: Bytes go out MSB first in SPI mode 0. SCLK idles low, MISO is sampled on each rising edge and MOSI changes after each falling edge. An SCLK period is CLK_DIV clock cycles, and consecutive bytes are separated by at least one SCLK period with SCLK low.
- R11: After reset the status word reads 0x5, the control word reads 0, both occupancy registers read 0, and ss_n is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects at the edge) |
| reg_addr | input | 7 | Byte offset of the word accessed |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed register |
| sclk | output | 1 | SPI serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | NSEL | Active-low slave selects |
| ev_rx_overrun | output | 1 | One-cycle pulse on a dropped received byte |
| ev_rx_nonempty | output | 1 | Receive FIFO holds data |
| ev_rx_full | output | 1 | Receive FIFO is full |
| ev_tx_empty | output | 1 | Transmit FIFO is empty |

## Verification
Read data is combinational, so the bench samples `reg_rdata` one time unit after driving the address. It samples the effect of a write or pop only after the following edge.

A byte starts one cycle after the transmit FIFO becomes non-empty and transfers are allowed. It occupies 8×CLK_DIV cycles on the wire and enters the receive FIFO one cycle after its last falling SCLK edge. A CLK_DIV-cycle gap then follows. The bench therefore waits at least 9×CLK_DIV+2 cycles per queued byte before it samples receive counts, status or overrun counters.

A scoreboard queue pairs the bytes seen on MOSI with those written. MISO is looped back inverted, so each received byte must equal the complement of the byte sent.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;

    // Register byte offsets
    localparam logic [6:0] OFS_RESET = 7'h40;
    localparam logic [6:0] OFS_CTRL  = 7'h60;
    localparam logic [6:0] OFS_STAT  = 7'h64;
    localparam logic [6:0] OFS_TXD   = 7'h68;
    localparam logic [6:0] OFS_RXD   = 7'h6C;
    localparam logic [6:0] OFS_SEL   = 7'h70;
    localparam logic [6:0] OFS_TXOCC = 7'h74;
    localparam logic [6:0] OFS_RXOCC = 7'h78;

    localparam logic [31:0] RESET_KEY  = 32'h0000_000A;
    localparam logic [31:0] EMPTY_MARK = 32'hDEAD_BEEF;

    // Control word bit positions
    localparam int CTRL_TXCLR   = 5;
    localparam int CTRL_RXCLR   = 6;
    localparam int CTRL_INHIBIT = 8;

    typedef enum logic [1:0] {
        SH_IDLE,
        SH_SHIFT,
        SH_GAP
    } sh_state_t;

    // Packed so that rx_empty lands in bit 0
    typedef struct packed {
        logic tx_full;
        logic tx_empty;
        logic rx_full;
        logic rx_empty;
    } stat_t;

    function automatic logic [31:0] occ_word(input logic [31:0] n);
        return (n == 32'd0) ? 32'd0 : n - 32'd1;
    endfunction

endpackage

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
    parameter  int DEPTH = 256,
    parameter  int W     = 8,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic          full,
    output logic          empty,
    output logic [CW-1:0] count
);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp];
    assign count   = cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= (int'(wp) == DEPTH - 1) ? '0 : wp + AW'(1);
            if (do_pop)  rp <= (int'(rp) == DEPTH - 1) ? '0 : rp + AW'(1);
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + CW'(1);
                2'b01:   cnt <= cnt - CW'(1);
                default: cnt <= cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    // R5
    fifo_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(DEPTH));

    // R2
    fifo_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> empty);

endmodule

// File: rtl/spi_shift_unit.sv
module spi_shift_unit
    import spi_host_pkg::*;
#(
    parameter  int CLK_DIV = 4,
    localparam int HALF    = CLK_DIV / 2,
    localparam int DW      = $clog2(CLK_DIV + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       busy,
    output logic       done,
    output logic [7:0] rx_byte,
    output logic       sclk,
    output logic       mosi
);

    sh_state_t     state;
    logic [DW-1:0] divcnt;
    logic [2:0]    bitcnt;
    logic [7:0]    tx_sh, rx_sh;
    logic          sclk_q, done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SH_IDLE;
            divcnt <= '0;
            bitcnt <= '0;
            tx_sh  <= '0;
            rx_sh  <= '0;
            sclk_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state)
                SH_IDLE: begin
                    if (start) begin
                        tx_sh  <= tx_byte;
                        bitcnt <= '0;
                        divcnt <= '0;
                        sclk_q <= 1'b0;
                        state  <= SH_SHIFT;
                    end
                end
                SH_SHIFT: begin
                    if (divcnt == DW'(HALF - 1)) begin
                        divcnt <= '0;
                        if (!sclk_q) begin
                            sclk_q <= 1'b1;
                            rx_sh  <= {rx_sh[6:0], miso};
                        end else begin
                            sclk_q <= 1'b0;
                            if (bitcnt == 3'd7) begin
                                state  <= SH_GAP;
                                done_q <= 1'b1;
                            end else begin
                                bitcnt <= bitcnt + 3'd1;
                                tx_sh  <= {tx_sh[6:0], 1'b0};
                            end
                        end
                    end else begin
                        divcnt <= divcnt + DW'(1);
                    end
                end
                SH_GAP: begin
                    if (divcnt == DW'(CLK_DIV - 1)) begin
                        divcnt <= '0;
                        state  <= SH_IDLE;
                    end else begin
                        divcnt <= divcnt + DW'(1);
                    end
                end
                default: state <= SH_IDLE;
            endcase
        end
    end

    assign busy    = (state != SH_IDLE);
    assign done    = done_q;
    assign rx_byte = rx_sh;
    assign sclk    = sclk_q;
    assign mosi    = tx_sh[7];

    // R10
    sclk_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (state != SH_SHIFT) |-> !sclk_q);

    // R3
    start_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (start && state == SH_IDLE) |=> (state == SH_SHIFT && !sclk_q));

endmodule

// File: rtl/spi_host_ctrl.sv
module spi_host_ctrl
    import spi_host_pkg::*;
#(
    parameter  int NSEL       = 1,
    parameter  int FIFO_DEPTH = 256,
    parameter  int CLK_DIV    = 4,
    localparam int CW         = $clog2(FIFO_DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            reg_wr,
    input  logic            reg_rd,
    input  logic [6:0]      reg_addr,
    input  logic [31:0]     reg_wdata,
    output logic [31:0]     reg_rdata,
    output logic            sclk,
    output logic            mosi,
    input  logic            miso,
    output logic [NSEL-1:0] ss_n,
    output logic            ev_rx_overrun,
    output logic            ev_rx_nonempty,
    output logic            ev_rx_full,
    output logic            ev_tx_empty
);

    logic            soft_rst, rst_all, ctrl_wr;
    logic            inhibit_q, ovr_q;
    logic [NSEL-1:0] sel_q;

    logic            tx_clr, tx_push, tx_full, tx_empty;
    logic [7:0]      tx_dout;
    logic [CW-1:0]   tx_cnt;
    logic            rx_clr, rx_pop, rx_full, rx_empty;
    logic [7:0]      rx_dout;
    logic [CW-1:0]   rx_cnt;
    logic            sh_start, sh_busy, sh_done;
    logic [7:0]      sh_rx;
    stat_t           stat;

    assign soft_rst = reg_wr && (reg_addr == OFS_RESET) && (reg_wdata == RESET_KEY);
    assign rst_all  = rst || soft_rst;
    assign ctrl_wr  = reg_wr && (reg_addr == OFS_CTRL);

    assign tx_clr   = ctrl_wr && reg_wdata[CTRL_TXCLR];
    assign rx_clr   = ctrl_wr && reg_wdata[CTRL_RXCLR];
    assign tx_push  = reg_wr && (reg_addr == OFS_TXD);
    assign rx_pop   = reg_rd && (reg_addr == OFS_RXD);
    assign sh_start = !sh_busy && !tx_empty && !inhibit_q && !tx_clr;

    spi_byte_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_txq (
        .clk(clk), .rst(rst_all), .clr(tx_clr),
        .push(tx_push), .din(reg_wdata[7:0]), .pop(sh_start),
        .dout(tx_dout), .full(tx_full), .empty(tx_empty), .count(tx_cnt)
    );

    spi_byte_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_rxq (
        .clk(clk), .rst(rst_all), .clr(rx_clr),
        .push(sh_done), .din(sh_rx), .pop(rx_pop),
        .dout(rx_dout), .full(rx_full), .empty(rx_empty), .count(rx_cnt)
    );

    spi_shift_unit #(.CLK_DIV(CLK_DIV)) u_shift (
        .clk(clk), .rst(rst_all), .start(sh_start), .tx_byte(tx_dout),
        .miso(miso), .busy(sh_busy), .done(sh_done), .rx_byte(sh_rx),
        .sclk(sclk), .mosi(mosi)
    );

    always_ff @(posedge clk) begin
        if (rst_all) begin
            inhibit_q <= 1'b0;
            sel_q     <= '1;
            ovr_q     <= 1'b0;
        end else begin
            ovr_q <= sh_done && rx_full;
            if (ctrl_wr) inhibit_q <= reg_wdata[CTRL_INHIBIT];
            if (reg_wr && reg_addr == OFS_SEL) sel_q <= reg_wdata[NSEL-1:0];
        end
    end

    assign stat = '{tx_full: tx_full, tx_empty: tx_empty,
                    rx_full: rx_full, rx_empty: rx_empty};

    always_comb begin
        case (reg_addr)
            OFS_CTRL:  reg_rdata = 32'(inhibit_q) << CTRL_INHIBIT;
            OFS_STAT:  reg_rdata = {28'd0, stat};
            OFS_RXD:   reg_rdata = rx_empty ? EMPTY_MARK : {24'd0, rx_dout};
            OFS_SEL:   reg_rdata = 32'(sel_q);
            OFS_TXOCC: reg_rdata = occ_word(32'(tx_cnt));
            OFS_RXOCC: reg_rdata = occ_word(32'(rx_cnt));
            default:   reg_rdata = 32'd0;
        endcase
    end

    assign ss_n           = sel_q;
    assign ev_rx_overrun  = ovr_q;
    assign ev_rx_nonempty = !rx_empty;
    assign ev_rx_full     = rx_full;
    assign ev_tx_empty    = tx_empty;

    // R7
    overrun_full_chk: assert property (@(posedge clk) disable iff (rst)
        ev_rx_overrun |-> $past(rx_full));

    // R1
    soft_reset_chk: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (ss_n == '1 && ev_tx_empty && !ev_rx_nonempty));

    // R3
    inhibit_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (inhibit_q && !sh_busy) |=> !sclk);

endmodule

// File: tb/sim_spi_host_ctrl.sv
module sim_spi_host_ctrl;
    import spi_host_pkg::*;

    localparam int NSEL = 2;
    localparam int DEPTH = 256;
    localparam int DIV = 4;
    localparam int BYTE_CYC = 9 * DIV + 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic reg_wr = 1'b0, reg_rd = 1'b0;
    logic [6:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic sclk, mosi, miso;
    logic [NSEL-1:0] ss_n;
    logic ev_rx_overrun, ev_rx_nonempty, ev_rx_full, ev_tx_empty;

    int checks = 0;
    int errors = 0;
    int sclk_rises = 0;
    int ovr_seen = 0;
    logic [7:0] wire_q[$];
    logic [7:0] rx_q[$];
    logic [7:0] mon_sh = '0;
    int mon_bits = 0;

    always #4 clk = ~clk;
    assign miso = ~mosi;

    spi_host_ctrl #(.NSEL(NSEL), .FIFO_DEPTH(DEPTH), .CLK_DIV(DIV)) u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n),
        .ev_rx_overrun(ev_rx_overrun), .ev_rx_nonempty(ev_rx_nonempty),
        .ev_rx_full(ev_rx_full), .ev_tx_empty(ev_tx_empty)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Wire monitor: R10, MSB-first capture on rising SCLK
    always @(posedge sclk) begin
        sclk_rises++;
        mon_sh = {mon_sh[6:0], mosi};
        mon_bits++;
        if (mon_bits == 8) begin
            mon_bits = 0;
            if (wire_q.size() == 0) check("R10 unexpected byte", 32'(mon_sh), 32'hFFFF_FFFF);
            else check("R10 wire byte", 32'(mon_sh), 32'(wire_q.pop_front()));
        end
    end

    always @(negedge clk) if (ev_rx_overrun) ovr_seen++;

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [6:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(req, v, exp);
    endtask

    // Driver: pushes expectations for the wire and for the receive FIFO
    task automatic send(input logic [7:0] b, input bit on_wire, input bit kept);
        if (on_wire) wire_q.push_back(b);
        if (kept) rx_q.push_back(~b);
        wr(OFS_TXD, {24'hABCDEF, b});
    endtask

    task automatic read_rx(input string req);
        logic [31:0] v;
        rd(OFS_RXD, v);
        if (rx_q.size() == 0) check(req, v, EMPTY_MARK);
        else check(req, v, {24'd0, rx_q.pop_front()});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int r0;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R11 reset state
        rd_chk("R11 status", OFS_STAT, 32'h5);
        rd_chk("R11 ctrl", OFS_CTRL, 32'h0);
        rd_chk("R11 txocc", OFS_TXOCC, 32'h0);
        rd_chk("R11 rxocc", OFS_RXOCC, 32'h0);
        check("R11 ss_n", 32'(ss_n), 32'h3);
        rd_chk("R8 select reset", OFS_SEL, 32'h3);

        // R3 inhibit holds bytes back
        wr(OFS_CTRL, 32'h100);
        r0 = sclk_rises;
        send(8'hA5, 1, 1); send(8'h3C, 1, 1); send(8'h81, 1, 1);
        repeat (100) @(negedge clk);
        check("R3 no sclk while inhibited", 32'(sclk_rises), 32'(r0));
        rd_chk("R9 txocc three", OFS_TXOCC, 32'h2);
        rd_chk("R4 status pending tx", OFS_STAT, 32'h1);
        check("R4 ev_tx_empty low", 32'(ev_tx_empty), 32'h0);

        // R3 clearing inhibit drains
        wr(OFS_CTRL, 32'h0);
        repeat (3 * BYTE_CYC + 20) @(negedge clk);
        check("R3 drained bytes", 32'(sclk_rises - r0), 32'd24);
        rd_chk("R9 txocc empty", OFS_TXOCC, 32'h0);
        rd_chk("R9 rxocc three", OFS_RXOCC, 32'h2);
        rd_chk("R4 status rx data", OFS_STAT, 32'h4);
        check("R4 ev_rx_nonempty", 32'(ev_rx_nonempty), 32'h1);
        for (int i = 0; i < 3; i++) read_rx("R6 rx byte");
        read_rx("R6 empty marker");
        rd_chk("R6 empty read pops nothing", OFS_RXOCC, 32'h0);

        // R4 status write ignored
        wr(OFS_STAT, 32'hF);
        rd_chk("R4 status write ignored", OFS_STAT, 32'h5);

        // R2 transmit clear
        wr(OFS_CTRL, 32'h100);
        send(8'h11, 0, 0); send(8'h22, 0, 0);
        rd_chk("R9 txocc two", OFS_TXOCC, 32'h1);
        wr(OFS_CTRL, 32'h120);
        rd_chk("R2 tx cleared", OFS_TXOCC, 32'h0);
        rd_chk("R2 status after tx clear", OFS_STAT, 32'h5);
        rd_chk("R2 clear bit not stored", OFS_CTRL, 32'h100);
        r0 = sclk_rises;
        wr(OFS_CTRL, 32'h0);
        repeat (2 * BYTE_CYC) @(negedge clk);
        check("R2 cleared bytes never sent", 32'(sclk_rises), 32'(r0));

        // R5 / R7 fill both FIFOs
        wr(OFS_CTRL, 32'h100);
        for (int i = 0; i < DEPTH; i++) send(8'(i), 1, 1);
        rd_chk("R4 tx full status", OFS_STAT, 32'h9);
        rd_chk("R9 txocc full", OFS_TXOCC, 32'hFF);
        send(8'hEE, 0, 0);
        rd_chk("R5 write when full dropped", OFS_TXOCC, 32'hFF);
        wr(OFS_CTRL, 32'h0);
        repeat (DEPTH * BYTE_CYC + 100) @(negedge clk);
        rd_chk("R4 rx full status", OFS_STAT, 32'h6);
        check("R4 ev_rx_full", 32'(ev_rx_full), 32'h1);
        rd_chk("R9 rxocc full", OFS_RXOCC, 32'hFF);
        check("R7 no overrun yet", 32'(ovr_seen), 32'd0);
        send(8'h55, 1, 0);
        repeat (BYTE_CYC + 10) @(negedge clk);
        check("R7 overrun pulse", 32'(ovr_seen), 32'd1);
        for (int i = 0; i < DEPTH; i++) read_rx("R7 kept byte");
        read_rx("R7 dropped byte absent");

        // R2 receive clear
        send(8'h5A, 1, 0); send(8'hC3, 1, 0);
        repeat (2 * BYTE_CYC + 10) @(negedge clk);
        rd_chk("R9 rxocc two", OFS_RXOCC, 32'h1);
        wr(OFS_CTRL, 32'h40);
        rd_chk("R2 rx cleared", OFS_RXOCC, 32'h0);
        rd_chk("R2 status after rx clear", OFS_STAT, 32'h5);
        rd_chk("R2 rx clear bit not stored", OFS_CTRL, 32'h0);

        // R8 selects
        wr(OFS_SEL, 32'h2);
        check("R8 ss_n 10", 32'(ss_n), 32'h2);
        wr(OFS_SEL, 32'h0);
        check("R8 ss_n 00", 32'(ss_n), 32'h0);
        rd_chk("R8 select readback", OFS_SEL, 32'h0);

        // R1 keyed soft reset
        wr(OFS_RESET, 32'h5);
        check("R1 wrong key ignored", 32'(ss_n), 32'h0);
        wr(OFS_CTRL, 32'h100);
        send(8'h77, 0, 0);
        wr(OFS_RESET, 32'hA);
        check("R1 ss_n after reset", 32'(ss_n), 32'h3);
        rd_chk("R1 status after reset", OFS_STAT, 32'h5);
        rd_chk("R1 txocc after reset", OFS_TXOCC, 32'h0);
        rd_chk("R1 ctrl after reset", OFS_CTRL, 32'h0);
        r0 = sclk_rises;
        repeat (2 * BYTE_CYC) @(negedge clk);
        check("R1 flushed byte not sent", 32'(sclk_rises), 32'(r0));

        check("R10 all expected bytes seen", 32'(wire_q.size()), 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule